// File: doc/BRIEF.md
# Digital Black Level Clamp Loop

This block removes the residual dark offset from a stream of converted image-sensor pixel codes. One pixel arrives per clock. On each line, a clamp window strobe marks the shielded (optical-black) pixels. Inside that window, the loop measures how far the corrected output sits from a programmable black target. It then moves a correction value by a filtered fraction of that distance. Between windows the correction is frozen. It is applied to every pixel, including the window pixels themselves, so the loop settles with the black pixels sitting on the target.

The target comes from an 8-bit level register. In 10-bit mode one register step is a quarter of an output LSB. In 12-bit mode one step is a full LSB. When the loop is disabled, the correction stops moving and the target itself is added to every pixel as a plain offset. All arithmetic is done in quarter-LSB units of the selected resolution, so the 10-bit fractional target is exact. The corrected result is floored back to whole codes and clipped to the code range of the selected resolution.

Top module: `blackClampLoop`

## Requirements
- R1: The accumulator changes only on cycles where the clamp window is active and the loop is enabled; on every other cycle it holds its value, and windows as short as one pixel still update it.
- R2: The window is active when `clampStrobe` equals `clampPol` (pol 1 = active high, pol 0 = active low).
- R3: With target T and corrected value Y both in quarter-LSB units, each window cycle adds T − Y to the accumulator, and the correction is the accumulator shifted arithmetically right by 4 bits (flooring), which low-pass filters the error.
- R4: The level register resets to 128 and is loaded from `levelIn` on a cycle with `levelWe` high; the new level takes effect from the next cycle.
- R5: The target in quarter-LSB units is the level when `res12` = 0 and four times the level when `res12` = 1.
- R6: While `loopDisable` is 1 the accumulator is frozen, and the output is floor((4·pix + T)/4) with no correction applied.
- R7: The accumulator saturates at ±(2^12 − 1)·16, which limits the correction to ±4095 quarter-LSBs.
- R8: The output saturates to 0..1023 when `res12` = 0 and to 0..4095 when `res12` = 1.
- R9: In 10-bit mode, `pixIn[11:10]` are ignored and the pixel is `pixIn[9:0]`.
- R10: The output is registered: the output for a pixel appears one clock after it is presented. Reset clears the output and the accumulator to 0.
- R11: With the loop enabled, the output is floor((4·pix + correction)/4) on every cycle, window cycles included. A constant black pixel held through a long window drives the output to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixIn | input | 12 | Converted pixel code |
| clampStrobe | input | 1 | Optical-black window strobe |
| clampPol | input | 1 | Active level of the window strobe |
| loopDisable | input | 1 | Freeze the loop and apply the target as a fixed offset |
| res12 | input | 1 | 1 = 12-bit codes, 0 = 10-bit codes |
| levelWe | input | 1 | Load strobe for the level register |
| levelIn | input | 8 | New black level value |
| pixOut | output | 12 | Corrected pixel code |

## Verification
The bench runs long windows of constant black pixels and checks that the output lands exactly on the target in both resolutions. A loop with the wrong error sign or the wrong scaling would run away or settle on another code. With the window strobe held at its inactive level, it changes the level and confirms the output stays fixed. It repeats this with the polarity inverted, which exposes a design that inverts the polarity or adapts outside the window. It then pushes codes past both rails and drives the correction into its clamp, where a missing saturation shows up as wrapped codes. In 10-bit mode it sets the top input bits, which a design that does not mask them turns into large codes. Disabled mode and a mid-run reset expose a leaking accumulator and a wrong level reset value through the fixed-offset output.

// File: rtl/blc_pkg.sv
package blc_pkg;
  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic clampUpdate;  // adapt the accumulator this cycle
    logic loopOn;       // apply accumulated correction (else fixed offset)
    logic res12;        // 12-bit code range selected
  } blcStrobes_t;
endpackage

// File: rtl/blcControl.sv
module blcControl
  import blc_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int LVL_RESET = 128,
  localparam int TW       = LVL_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clampStrobe,
  input  logic             clampPol,
  input  logic             loopDisable,
  input  logic             res12,
  input  logic             levelWe,
  input  logic [LVL_W-1:0] levelIn,
  output blcStrobes_t      strobes,
  output logic [TW-1:0]    targetQ
);
  logic [LVL_W-1:0] levelReg;
  logic             windowActive;

  always_ff @(posedge clk) begin
    if (!rstN)        levelReg <= LVL_W'(LVL_RESET);
    else if (levelWe) levelReg <= levelIn;
  end

  // Window decode: strobe level equal to the selected polarity.
  assign windowActive = ~(clampStrobe ^ clampPol);

  always_comb begin
    strobes.clampUpdate = windowActive & ~loopDisable;
    strobes.loopOn      = ~loopDisable;
    strobes.res12       = res12;
    // Target in quarter-LSB units of the active resolution.
    if (res12) targetQ = {levelReg, 2'b00};
    else       targetQ = {2'b00, levelReg};
  end

  // R4: level register only moves on a write strobe
  assert_level_write_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    !levelWe |=> $stable(levelReg));
endmodule

// File: rtl/blcDatapath.sv
module blcDatapath
  import blc_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int LVL_W = 8,
  parameter int SHIFT = 4,
  localparam int TW   = LVL_W + 2,
  localparam int QW   = PIX_W + 2,
  localparam int YW   = QW + 3,
  localparam int AW   = QW + SHIFT + 2,
  localparam int CORR_LIM = (1 << PIX_W) - 1,
  localparam int ACC_LIM  = CORR_LIM << SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  blcStrobes_t      strobes,
  input  logic [TW-1:0]    targetQ,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] pixOut
);
  localparam logic signed [AW-1:0] ACC_MAX = AW'(ACC_LIM);
  localparam logic signed [AW-1:0] ACC_MIN = -ACC_MAX;

  logic signed [AW-1:0] acc, corrFull, errQ, accSum, accNext;
  logic signed [YW-1:0] pixQ, offsetQ, yQ, yLsb, maxCodeS, targetS;
  logic [PIX_W-1:0]     pixMasked, maxCode, pixNext;

  always_comb begin
    pixMasked = pixIn;
    if (!strobes.res12) pixMasked[PIX_W-1:PIX_W-2] = 2'b00;
    maxCode = '1;
    if (!strobes.res12) maxCode[PIX_W-1:PIX_W-2] = 2'b00;
  end

  assign pixQ     = $signed({{(YW-QW){1'b0}}, pixMasked, 2'b00});
  assign targetS  = $signed({{(YW-TW){1'b0}}, targetQ});
  assign maxCodeS = $signed({{(YW-PIX_W){1'b0}}, maxCode});
  assign corrFull = acc >>> SHIFT;
  assign offsetQ  = strobes.loopOn ? corrFull[YW-1:0] : targetS;
  assign yQ       = pixQ + offsetQ;
  assign yLsb     = yQ >>> 2;

  always_comb begin
    if (yLsb < 0)             pixNext = '0;
    else if (yLsb > maxCodeS) pixNext = maxCode;
    else                      pixNext = yLsb[PIX_W-1:0];
  end

  // Error and saturating accumulate.
  assign errQ   = $signed({{(AW-TW){1'b0}}, targetQ}) - {{(AW-YW){yQ[YW-1]}}, yQ};
  assign accSum = acc + errQ;

  always_comb begin
    if (accSum > ACC_MAX)      accNext = ACC_MAX;
    else if (accSum < ACC_MIN) accNext = ACC_MIN;
    else                       accNext = accSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      pixOut <= '0;
    end else begin
      pixOut <= pixNext;
      if (strobes.clampUpdate) acc <= accNext;
    end
  end

  // R7: accumulator stays inside its bounds
  assert_acc_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (acc <= ACC_MAX) && (acc >= ACC_MIN));

  // R1: correction held whenever the control does not request an update
  assert_hold_between_windows_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clampUpdate |=> $stable(acc));

  // R8: 10-bit mode never produces codes above 1023
  assert_out_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.res12 |=> (pixOut[PIX_W-1:PIX_W-2] == 2'b00));
endmodule

// File: rtl/blackClampLoop.sv
module blackClampLoop
  import blc_pkg::*;
#(
  parameter int PIX_W     = 12,
  parameter int LVL_W     = 8,
  parameter int SHIFT     = 4,
  parameter int LVL_RESET = 128,
  localparam int TW       = LVL_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             clampStrobe,
  input  logic             clampPol,
  input  logic             loopDisable,
  input  logic             res12,
  input  logic             levelWe,
  input  logic [LVL_W-1:0] levelIn,
  output logic [PIX_W-1:0] pixOut
);
  blcStrobes_t   strobes;
  logic [TW-1:0] targetQ;

  blcControl #(.LVL_W(LVL_W), .LVL_RESET(LVL_RESET)) uCtrl (
    .clk(clk), .rstN(rstN), .clampStrobe(clampStrobe), .clampPol(clampPol),
    .loopDisable(loopDisable), .res12(res12), .levelWe(levelWe),
    .levelIn(levelIn), .strobes(strobes), .targetQ(targetQ)
  );

  blcDatapath #(.PIX_W(PIX_W), .LVL_W(LVL_W), .SHIFT(SHIFT)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .targetQ(targetQ),
    .pixIn(pixIn), .pixOut(pixOut)
  );
endmodule

// File: tb/tb_blackClampLoop.sv
module tb_blackClampLoop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] pixIn = '0;
  logic        clampStrobe = 1'b0, clampPol = 1'b1, loopDisable = 1'b0, res12 = 1'b0;
  logic        levelWe = 1'b0;
  logic [7:0]  levelIn = '0;
  logic [11:0] pixOut;

  blackClampLoop dut (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .clampStrobe(clampStrobe),
    .clampPol(clampPol), .loopDisable(loopDisable), .res12(res12),
    .levelWe(levelWe), .levelIn(levelIn), .pixOut(pixOut)
  );

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int expQ[$];
  string tagQ[$];
  // Configuration the next vector will use, and the reference model state.
  bit cPol = 1'b1, cDis = 1'b0, cR12 = 1'b0;
  int mAcc = 0, mLvl = 128;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: pixOut=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(int pix, bit strobe, bit we, int lvl, string tag);
    int pm, pq, tq, corr, y, o, mx, s;
    @(negedge clk);
    pixIn = 12'(pix); clampStrobe = strobe; clampPol = cPol;
    loopDisable = cDis; res12 = cR12; levelWe = we; levelIn = 8'(lvl);
    pm = cR12 ? pix : (pix & 1023);
    pq = pm * 4;
    tq = cR12 ? mLvl * 4 : mLvl;
    corr = mAcc >>> 4;
    y = pq + (cDis ? tq : corr);
    o = y >>> 2;
    mx = cR12 ? 4095 : 1023;
    if (o < 0) o = 0;
    if (o > mx) o = mx;
    if (strobe == cPol && !cDis) begin
      s = mAcc + tq - y;
      if (s > 65520) s = 65520;
      if (s < -65520) s = -65520;
      mAcc = s;
    end
    if (we) mLvl = lvl;
    expQ.push_back(o);
    tagQ.push_back(tag);
  endtask

  // Direct check of the output produced by the most recent vector.
  task automatic expectNow(string tag, int exp);
    @(posedge clk); #6;
    check(tag, int'(pixOut), exp);
  endtask

  task automatic doReset();
    repeat (3) @(negedge clk);
    rstN = 1'b0; levelWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mAcc = 0; mLvl = 128;
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(posedge clk); #5;
      if (expQ.size() > 0) check(tagQ.pop_front(), int'(pixOut), expQ.pop_front());
    end
  end

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #6;
    check("R10 reset output", int'(pixOut), 0);

    // Pass-through with zero correction, 10-bit, pol high.
    for (int i = 0; i < 16; i++) drive(i * 50, 0, 0, 0, "R10 latency/pass");
    drive(12'hC05, 0, 0, 0, "R9 top bits ignored");
    expectNow("R9 top bits ignored", 5);

    // Long window of black pixels converges to 32 LSB target.
    for (int i = 0; i < 200; i++) drive(10, 1, 0, 0, "R11 converge");
    expectNow("R11 converged to target", 32);
    for (int i = 0; i < 10; i++) drive(100, 0, 0, 0, "R1 hold");
    expectNow("R1 correction held", 122);

    // Inverted polarity: high strobe now inactive; change level while inactive.
    cPol = 1'b0;
    drive(10, 1, 1, 200, "R4 level write");
    for (int i = 0; i < 30; i++) drive(10, 1, 0, 0, "R2 inactive high");
    expectNow("R2 no adaptation when strobe inactive", 32);
    for (int i = 0; i < 200; i++) drive(10, 0, 0, 0, "R2 active low window");
    expectNow("R5 10-bit level 200 -> 50 LSB", 50);

    // Short windows.
    drive(300, 1, 1, 128, "R4 level write");
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 3; i++) drive(10, 0, 0, 0, "R1 short window");
      for (int i = 0; i < 8; i++) drive(300 + i, 1, 0, 0, "R3 between windows");
    end

    // Disabled: fixed offset of 32 LSB, accumulator frozen.
    cDis = 1'b1;
    for (int i = 0; i < 20; i++) drive(10, 0, 0, 0, "R6 disabled");
    expectNow("R6 fixed offset", 42);
    drive(1020, 1, 0, 0, "R8 high clip 10-bit");
    expectNow("R8 high clip 10-bit", 1023);
    cR12 = 1'b1;
    drive(4090, 1, 0, 0, "R8 high clip 12-bit");
    expectNow("R8 high clip 12-bit", 4095);
    drive(100, 1, 0, 0, "R5 12-bit offset");
    expectNow("R5 12-bit offset", 228);
    cDis = 1'b0;
    for (int i = 0; i < 10; i++) drive(300, 1, 0, 0, "R6 resume held acc");

    // 12-bit convergence, pol high.
    cPol = 1'b1;
    for (int i = 0; i < 250; i++) drive(40, 1, 0, 0, "R5 12-bit converge");
    expectNow("R5 12-bit target 128", 128);

    // Drive the correction into its clamp.
    drive(3000, 0, 1, 0, "R4 level write");
    for (int i = 0; i < 80; i++) drive(3000, 1, 0, 0, "R7 saturate");
    expectNow("R7 correction clamped", 1976);
    cR12 = 1'b0;
    drive(100, 0, 0, 0, "R8 low clip");
    expectNow("R8 low clip", 0);

    // Mid-run reset restores level 128 and clears the accumulator.
    doReset();
    cDis = 1'b1;
    drive(0, 0, 0, 0, "R4 reset level");
    expectNow("R4 reset level 128", 32);
    cDis = 1'b0;
    drive(7, 0, 0, 0, "R10 acc cleared");
    expectNow("R10 acc cleared", 7);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule